// File: doc/BRIEF.md
# Refresh-Aware Per-Bank Request Arbiter

This block sits inside a memory controller, between the stream of incoming memory requests and the port that issues commands to the DRAM. Every request names a target bank, an address and a read/write flag. The request is written into a small queue that belongs to that bank only. One bank at a time may be taken offline for refresh. The block never sends a request to that bank. It keeps serving every other bank, so a waiting request for a refreshing bank cannot hold up unrelated traffic.

Each clock cycle the arbiter looks at the head of every queue. It treats as eligible each bank whose queue is non-empty and whose refresh flag is low. It grants one eligible bank in round-robin order, starting its search at the bank after the previous grant. The issue path is combinational from the queue heads and the refresh flags. The granted entry is popped at the clock edge that ends the issue cycle.

Each bank queue is controlled by a three-state machine:
- `Q_EMPTY` holds no entries.
- `Q_HOLD` holds between one and depth-1 entries.
- `Q_FULL` holds depth entries.

The transitions are:
- fill: `Q_EMPTY` to `Q_HOLD` on a push.
- top-off: `Q_HOLD` to `Q_FULL` on a push alone that reaches depth.
- drain-last: `Q_HOLD` to `Q_EMPTY` on a pop alone of the last entry.
- release: `Q_FULL` to `Q_HOLD` on a pop.

A push together with a pop leaves the state unchanged.

Top module: `bank_req_arbiter`

## Requirements
- R1: After reset every queue is empty: `q_empty` is all ones, `q_full` is all zeros and `out_valid` is 0.
- R2: `in_ready` equals the inverse of `q_full` for the bank named by `in_bank`. A request offered while that queue is full is not stored and never issues.
- R3: `q_full[b]` is 1 exactly when bank b's queue holds 4 entries. `q_empty[b]` is 1 exactly when it holds none.
- R4: Requests for one bank issue in the order they were accepted. Each issued request carries the same address and write flag (1 = write) that it was accepted with.
- R5: No request is issued for a bank whose `refresh_busy` bit is 1. The operating condition is that at most one `refresh_busy` bit is 1 at a time.
- R6: A non-empty queue whose bank is refreshing does not block other banks. If any other bank has a waiting request and is not refreshing, one is issued in that same cycle.
- R7: Among eligible banks the grant goes to the first one found searching upward from the bank after the last granted bank, wrapping from bank 7 to bank 0.
- R8: `out_valid` is 1 in a cycle exactly when some bank has a non-empty queue and a low refresh bit. If every non-empty queue belongs to a refreshing bank, nothing issues.
- R9: At most one request issues per cycle. A request accepted at a clock edge can issue from the next cycle onward, and the issued entry leaves its queue at the edge that ends the issue cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming request present |
| in_ready | output | 1 | Incoming request can be accepted this cycle |
| in_bank | input | 3 | Target bank of the incoming request |
| in_addr | input | 16 | Address of the incoming request |
| in_write | input | 1 | 1 = write, 0 = read |
| refresh_busy | input | 8 | One bit per bank, 1 = bank under refresh |
| out_valid | output | 1 | A request is issued this cycle |
| out_bank | output | 3 | Bank of the issued request |
| out_addr | output | 16 | Address of the issued request |
| out_write | output | 1 | Write flag of the issued request |
| q_full | output | 8 | Per-bank queue full |
| q_empty | output | 8 | Per-bank queue empty |

## Verification
The hardest condition to reach from the ports is two banks holding waiting requests at the same time. Requests arrive one per cycle and leave one per cycle, so a queue normally drains as fast as it fills. The stimulus builds up a backlog by holding one bank's refresh bit high while its queue fills. It then drops the refresh and, in the same cycles, feeds a second bank. This creates real contention, which shows round-robin alternation, pointer wrap-around and per-bank ordering. Keeping the refresh bit high also parks a full queue, which exposes back-pressure and the skip past a blocked head.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

    // Occupancy state of one per-bank request queue
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_HOLD  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_t;

endpackage

// File: rtl/bank_queue.sv
module bank_queue
    import bank_arb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    qstate_t          state, state_nxt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (push) state_nxt = Q_HOLD;                     // fill
            end
            Q_HOLD: begin
                if (push && !pop && count == CNT_TOP)
                    state_nxt = Q_FULL;                           // top-off
                else if (pop && !push && count == CNT_ONE)
                    state_nxt = Q_EMPTY;                          // drain-last
            end
            Q_FULL: begin
                if (pop && !push) state_nxt = Q_HOLD;             // release
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        full      = (state == Q_FULL);
        empty     = (state == Q_EMPTY);
        head_data = slots[rd_ptr];
    end

    // Pointers and occupancy count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage, no reset needed
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    // A full queue is never written
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));

    // An empty queue is never popped
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

    // State flags agree with the independent count
    assert_empty_matches_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY) == (count == '0));

    assert_full_matches_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) == (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic                 grant_valid,
    output logic [$clog2(N)-1:0] grant_idx
);

    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cand;

    // Search upward from the bank after the last grant, wrapping
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        cand        = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IDX_W'((int'(last_q) + k) % N);
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           last_q <= IDX_W'(N - 1);
        else if (grant_valid) last_q <= grant_idx;
    end

    // A grant always lands on a requester
    assert_grant_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req[grant_idx]);

    // Grant pointer follows the previous grant
    assert_pointer_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (last_q == $past(grant_idx)));

endmodule

// File: rtl/bank_req_arbiter.sv
module bank_req_arbiter
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int QUEUE_DEPTH = 4,
    parameter int ADDR_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [$clog2(NUM_BANKS)-1:0] in_bank,
    input  logic [ADDR_W-1:0]            in_addr,
    input  logic                         in_write,
    input  logic [NUM_BANKS-1:0]         refresh_busy,
    output logic                         out_valid,
    output logic [$clog2(NUM_BANKS)-1:0] out_bank,
    output logic [ADDR_W-1:0]            out_addr,
    output logic                         out_write,
    output logic [NUM_BANKS-1:0]         q_full,
    output logic [NUM_BANKS-1:0]         q_empty
);

    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int ENTRY_W = ADDR_W + 1;

    logic [ENTRY_W-1:0] head_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] eligible;
    logic                 grant_valid;
    logic [BANK_W-1:0]    grant_idx;
    logic                 accept;

    assign in_ready = !q_full[in_bank];
    assign accept   = in_valid && in_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic push_b, pop_b;
        assign push_b      = accept && (in_bank == BANK_W'(b));
        assign pop_b       = grant_valid && (grant_idx == BANK_W'(b));
        assign eligible[b] = !q_empty[b] && !refresh_busy[b];

        bank_queue #(
            .DEPTH (QUEUE_DEPTH),
            .WIDTH (ENTRY_W)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_b),
            .push_data ({in_addr, in_write}),
            .pop       (pop_b),
            .head_data (head_q[b]),
            .full      (q_full[b]),
            .empty     (q_empty[b])
        );
    end

    rr_picker #(
        .N (NUM_BANKS)
    ) u_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (eligible),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    always_comb begin
        out_valid = grant_valid;
        out_bank  = grant_idx;
        {out_addr, out_write} = head_q[grant_idx];
    end

    // Operating condition: one refreshing bank at most
    assert_single_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(refresh_busy));

    // Never issue into a refreshing bank
    assert_skip_refreshing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !refresh_busy[out_bank]);

    // Issue whenever a bank is both waiting and online
    assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q_empty & ~refresh_busy) != '0) |-> out_valid);

    // Nothing issues when only refreshing banks hold work
    assert_idle_when_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q_empty & ~refresh_busy) == '0) |-> !out_valid);

    // Issued bank has work waiting
    assert_issue_from_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !q_empty[out_bank]);

endmodule

// File: tb/tb_bank_req_arbiter.sv
module tb_bank_req_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_bank;
    logic [15:0] in_addr;
    logic        in_write;
    logic [7:0]  refresh_busy;
    logic        out_valid;
    logic [2:0]  out_bank;
    logic [15:0] out_addr;
    logic        out_write;
    logic [7:0]  q_full;
    logic [7:0]  q_empty;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bank_req_arbiter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_bank      (in_bank),
        .in_addr      (in_addr),
        .in_write     (in_write),
        .refresh_busy (refresh_busy),
        .out_valid    (out_valid),
        .out_bank     (out_bank),
        .out_addr     (out_addr),
        .out_write    (out_write),
        .q_full       (q_full),
        .q_empty      (q_empty)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_issue(input string req, input int bank, input int addr, input int wr);
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "out_bank",  int'(out_bank),  bank);
        check(req, "out_addr",  int'(out_addr),  addr);
        check(req, "out_write", int'(out_write), wr);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_bank = '0; in_addr = '0;
        in_write = 1'b0; refresh_busy = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #5;
        check("R1", "q_empty", int'(q_empty), 8'hFF);
        check("R1", "q_full",  int'(q_full),  0);
        check("R1", "out_valid", int'(out_valid), 0);
    endtask

    // Fill a refreshing bank, push one past full, then drain in order
    task automatic test_fill_backpressure();
        refresh_busy = 8'h08;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_bank = 3'd3;
            in_addr = 16'h0100 + 16'(i); in_write = i[0];
        end
        @(negedge clk);
        in_addr = 16'h01FF; in_write = 1'b1;
        #5;
        check("R3", "q_full[3]",  int'(q_full[3]),  1);
        check("R3", "q_empty[3]", int'(q_empty[3]), 0);
        check("R2", "in_ready when full", int'(in_ready), 0);
        check("R8", "out_valid blocked", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0; refresh_busy = '0;
        #5;
        check_issue("R4", 3, 16'h0100, 0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); #5;
            check_issue("R9", 3, 16'h0100 + i, i % 2);
        end
        @(negedge clk); #5;
        check("R2", "refused request absent", int'(out_valid), 0);
        check("R3", "q_empty[3] after drain", int'(q_empty[3]), 1);
    endtask

    // Blocked head in bank 2 must not hold bank 5
    task automatic test_skip_refresh();
        refresh_busy = 8'h04;
        @(negedge clk);
        in_valid = 1'b1; in_bank = 3'd2; in_addr = 16'h0200; in_write = 1'b1;
        @(negedge clk);
        in_addr = 16'h0201; in_write = 1'b0;
        @(negedge clk);
        in_bank = 3'd5; in_addr = 16'h0500; in_write = 1'b1;
        #5;
        check("R8", "only refreshing bank waiting", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        #5;
        check_issue("R6", 5, 16'h0500, 1);
        check("R5", "bank 2 still held", int'(q_empty[2]), 0);
        @(negedge clk); #5;
        check("R5", "no issue into refreshing bank", int'(out_valid), 0);
        @(negedge clk);
        refresh_busy = '0;
        #5;
        check_issue("R4", 2, 16'h0200, 1);
        @(negedge clk); #5;
        check_issue("R4", 2, 16'h0201, 0);
        @(negedge clk); #5;
        check("R8", "idle after drain", int'(out_valid), 0);
    endtask

    // Backlog in bank 4 contends with a stream into bank 1
    task automatic test_round_robin();
        int exp_bank [7] = '{4, 1, 4, 1, 4, 1, 4};
        int exp_addr [7] = '{16'h0400, 16'h0110, 16'h0401, 16'h0111,
                             16'h0402, 16'h0112, 16'h0403};
        refresh_busy = 8'h10;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_bank = 3'd4;
            in_addr = 16'h0400 + 16'(i); in_write = 1'b0;
        end
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            refresh_busy = '0;
            if (c < 3) begin
                in_valid = 1'b1; in_bank = 3'd1;
                in_addr = 16'h0110 + 16'(c); in_write = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            #5;
            check_issue("R7", exp_bank[c], exp_addr[c], (exp_bank[c] == 1) ? 1 : 0);
        end
        @(negedge clk); #5;
        check("R8", "idle after contention", int'(out_valid), 0);
        check("R3", "all queues empty", int'(q_empty), 8'hFF);
    endtask

    initial begin
        test_reset();
        test_fill_backpressure();
        test_skip_refresh();
        test_round_robin();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule